// File: doc/BRIEF.md
# Serial Peripheral Master Shift Engine

This block is a single-channel SPI master that runs entirely from the system clock. One start strobe carries out one transfer. Chip select goes low, the engine waits out a lead delay, and then it clocks a word of 8 to 16 bits out on MOSI, MSB first, while it captures the same number of bits from MISO. At the end it raises chip select and pulses `done_o` together with the received word.

Four settings come in through a single-cycle configuration write:
- a word-length code,
- a serial clock divider,
- a lead delay,
- a trail delay that holds off the next start.

The engine copies these settings when it accepts a start, so a write made during a transfer only affects later transfers. A start with an unusable setting is refused and reported on a sticky error flag.

Top module: `spi_xfer_engine`

## Requirements
- R1: Length code n in 0..8 gives a word of 8+n bits. MOSI sends `tx_data_i[7+n:0]` MSB first. `rx_data_o` holds the MISO bits right-aligned, with the first bit received in the most significant position, and all bits above bit 7+n are zero.
- R2: For a divider value d of 2 or more, one SCK period is d system clock cycles. The high phase lasts floor(d/2) cycles and the low phase lasts d-floor(d/2) cycles. A divider of 1 behaves like a divider of 2.
- R3: Mode 0. SCK is low whenever chip select is inactive. MOSI changes only while SCK is low and holds still through every high phase. MISO is captured on the rising edge of SCK.
- R4: After a start is accepted, chip select is low in the next cycle. The first rising edge of SCK follows L cycles later, where L is the lead setting. When L is 0, the first rising edge comes after the low-phase length from R2.
- R5: Chip select returns high on the last falling edge of SCK. A start is ignored for the T cycles that follow, where T is the trail setting. A start present in the cycle after those T cycles is accepted.
- R6: `done_o` is high for exactly one cycle. That cycle is the last falling edge, and in it `rx_data_o` takes the new word.
- R7: A start made while the stored divider is 0, or while the stored length code is 9 to 15, is ignored and sets `cfg_err_o`. The flag stays set until a configuration write with a nonzero divider and a code of 8 or less. A write with invalid values leaves the flag as it is.
- R8: After reset, chip select is high, SCK is low, `done_o` and `cfg_err_o` are low, `rx_data_o` is 0, and the stored divider is 0, so the first start needs a configuration write beforehand.
- R9: A start strobe that arrives during a transfer is ignored. The transfer in progress completes with its original data.
- R10: A configuration write is used from the next cycle onward. A start in the same cycle as a write is judged against the earlier settings. When that start is refused and the write is valid, the clearing of `cfg_err_o` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_len_i | input | 4 | Word-length code |
| cfg_div_i | input | 8 | SCK divider |
| cfg_lead_i | input | 8 | Chip-select-to-first-edge delay |
| cfg_trail_i | input | 8 | Hold-off after a transfer |
| start_i | input | 1 | Transfer request strobe |
| tx_data_i | input | 16 | Word to send, right-aligned |
| rx_data_o | output | 16 | Last received word, right-aligned |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err_o | output | 1 | Sticky refused-start flag |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
Two functions can fall in the same cycle: a configuration write and a start request. The bench provokes this by presenting a valid write together with a start while the stored divider is still 0. It then expects chip select to stay high, because the start is judged on the old settings, and `cfg_err_o` to be low, because clearing wins. A second collision places a start one cycle before the trail window ends and holds it into the first free cycle. The bench checks that chip select stays high after the first of those cycles and falls after the second.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL
  } xfer_state_e;
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int LEN_W    = 4,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 8,
  parameter int MAX_CODE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] trail_i,
  input  logic             start_rej_i,
  output logic [LEN_W-1:0] len_o,
  output logic [DIV_W-1:0] div_o,
  output logic [DLY_W-1:0] lead_o,
  output logic [DLY_W-1:0] trail_o,
  output logic             cfg_ok_o,
  output logic             cfg_err_o
);
  logic new_ok;

  assign new_ok   = (div_i != '0) && (int'(len_i) <= MAX_CODE);
  assign cfg_ok_o = (div_o != '0) && (int'(len_o) <= MAX_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o   <= '0;
      div_o   <= '0;
      lead_o  <= '0;
      trail_o <= '0;
    end else if (we_i) begin
      len_o   <= len_i;
      div_o   <= div_i;
      lead_o  <= lead_i;
      trail_o <= trail_i;
    end
  end

  // clear has priority over a refused start in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_err_o <= 1'b0;
    else if (we_i && new_ok)    cfg_err_o <= 1'b0;
    else if (start_rej_i)       cfg_err_o <= 1'b1;
  end

  assert_err_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $past(start_rej_i));
  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && new_ok) |=> !cfg_err_o);
  assert_err_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !we_i) |=> cfg_err_o);
endmodule

// File: rtl/spi_phase_calc.sv
module spi_phase_calc #(
  parameter int DIV_W = 8,
  parameter int DLY_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] lead_i,
  output logic [CNT_W-1:0] hi_len_o,
  output logic [CNT_W-1:0] lo_len_o,
  output logic [CNT_W-1:0] lead_len_o
);
  logic [DIV_W-1:0] half;

  assign half = div_i >> 1;

  always_comb begin
    if (div_i < DIV_W'(2)) begin
      hi_len_o = CNT_W'(1);
      lo_len_o = CNT_W'(1);
    end else begin
      hi_len_o = CNT_W'(half);
      lo_len_o = CNT_W'(div_i - half);
    end
    lead_len_o = (lead_i != '0) ? CNT_W'(lead_i) : lo_len_o;
  end

  assert_phase_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i > DIV_W'(1)) |-> (32'(hi_len_o) + 32'(lo_len_o) == 32'(div_i)));
  assert_low_ge_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_len_o >= hi_len_o);
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 4,
  parameter int CNT_W    = 8,
  parameter int MIN_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cfg_ok_i,
  input  logic [LEN_W-1:0]  len_code_i,
  input  logic [CNT_W-1:0]  hi_len_i,
  input  logic [CNT_W-1:0]  lo_len_i,
  input  logic [CNT_W-1:0]  lead_len_i,
  input  logic [CNT_W-1:0]  trail_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              miso_i,
  output logic              start_rej_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int BIT_W = $clog2(DATA_W + 1);

  xfer_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q, hi_q, lo_q, trail_q;
  logic [BIT_W-1:0]  nbits_w, nbits_q, left_q;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              idle, accept, last_cnt;

  assign idle        = (state_q == ST_IDLE);
  assign accept      = start_i && idle && cfg_ok_i;
  assign start_rej_o = start_i && idle && !cfg_ok_i;
  assign nbits_w     = BIT_W'(MIN_BITS) + BIT_W'(len_code_i);
  assign last_cnt    = (cnt_q == CNT_W'(1));
  assign mosi_o      = tx_sh[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      trail_q   <= '0;
      nbits_q   <= '0;
      left_q    <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sck_o     <= 1'b0;
      cs_no     <= 1'b1;
      done_o    <= 1'b0;
      rx_data_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cs_no   <= 1'b0;
          state_q <= ST_LEAD;
          cnt_q   <= lead_len_i;
          hi_q    <= hi_len_i;
          lo_q    <= lo_len_i;
          trail_q <= trail_i;
          nbits_q <= nbits_w;
          left_q  <= nbits_w;
          tx_sh   <= tx_data_i << (BIT_W'(DATA_W) - nbits_w);
          rx_sh   <= '0;
        end
        ST_LEAD, ST_LOW: begin
          if (last_cnt) begin
            sck_o   <= 1'b1;
            rx_sh   <= {rx_sh[DATA_W-2:0], miso_i};
            cnt_q   <= hi_q;
            state_q <= ST_HIGH;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HIGH: begin
          if (last_cnt) begin
            sck_o <= 1'b0;
            if (left_q == BIT_W'(1)) begin
              cs_no     <= 1'b1;
              done_o    <= 1'b1;
              rx_data_o <= rx_sh;
              tx_sh     <= '0;
              cnt_q     <= trail_q;
              state_q   <= (trail_q == '0) ? ST_IDLE : ST_TRAIL;
            end else begin
              left_q  <= left_q - 1'b1;
              tx_sh   <= tx_sh << 1;
              cnt_q   <= lo_q;
              state_q <= ST_LOW;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (last_cnt) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !sck_o && $past(sck_o)));
  assert_sck_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  assert_mosi_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  assert_rx_upper_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((rx_data_o >> nbits_q) == '0));
  assert_trail_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRAIL) |-> cs_no);
  assert_reject_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rej_o |=> cs_no);
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 4,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 8,
  parameter int MIN_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [DLY_W-1:0]  cfg_lead_i,
  input  logic [DLY_W-1:0]  cfg_trail_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              cfg_err_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_no,
  input  logic              miso_i
);
  localparam int MAX_CODE = DATA_W - MIN_BITS;
  localparam int CNT_W    = (DLY_W > DIV_W) ? DLY_W : DIV_W;

  logic [LEN_W-1:0] len_q;
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] lead_q, trail_q;
  logic [CNT_W-1:0] hi_len, lo_len, lead_len;
  logic             cfg_ok, start_rej;

  spi_cfg_regs #(
    .LEN_W(LEN_W), .DIV_W(DIV_W), .DLY_W(DLY_W), .MAX_CODE(MAX_CODE)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i),
    .len_i      (cfg_len_i),
    .div_i      (cfg_div_i),
    .lead_i     (cfg_lead_i),
    .trail_i    (cfg_trail_i),
    .start_rej_i(start_rej),
    .len_o      (len_q),
    .div_o      (div_q),
    .lead_o     (lead_q),
    .trail_o    (trail_q),
    .cfg_ok_o   (cfg_ok),
    .cfg_err_o  (cfg_err_o)
  );

  spi_phase_calc #(
    .DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)
  ) u_phase (
    .clk_i, .rst_ni,
    .div_i     (div_q),
    .lead_i    (lead_q),
    .hi_len_o  (hi_len),
    .lo_len_o  (lo_len),
    .lead_len_o(lead_len)
  );

  spi_xfer_ctrl #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_BITS(MIN_BITS)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .start_i    (start_i),
    .cfg_ok_i   (cfg_ok),
    .len_code_i (len_q),
    .hi_len_i   (hi_len),
    .lo_len_i   (lo_len),
    .lead_len_i (lead_len),
    .trail_i    (CNT_W'(trail_q)),
    .tx_data_i  (tx_data_i),
    .miso_i     (miso_i),
    .start_rej_o(start_rej),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .cs_no      (cs_no),
    .done_o     (done_o),
    .rx_data_o  (rx_data_o)
  );
endmodule

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, start_i = 1'b0;
  logic [3:0]  cfg_len_i = '0;
  logic [7:0]  cfg_div_i = '0, cfg_lead_i = '0, cfg_trail_i = '0;
  logic [15:0] tx_data_i = '0, rx_data_o;
  logic        done_o, cfg_err_o, sck_o, mosi_o, cs_no, miso_i;

  int          n_chk = 0, n_fail = 0;
  int          bi = 0, cur_n = 8;
  logic [15:0] cur_sw = '0;

  always #2 clk = ~clk;

  // slave model: next bit presented after each falling edge
  assign miso_i = (bi < cur_n) ? cur_sw[cur_n-1-bi] : 1'b0;

  spi_xfer_engine dut (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_len_i, .cfg_div_i, .cfg_lead_i,
    .cfg_trail_i, .start_i, .tx_data_i, .rx_data_o, .done_o, .cfg_err_o,
    .sck_o, .mosi_o, .cs_no, .miso_i
  );

  function automatic int exp_hi(int d);  return (d < 2) ? 1 : d / 2;     endfunction
  function automatic int exp_lo(int d);  return (d < 2) ? 1 : d - d / 2; endfunction
  function automatic int exp_lead(int l, int d); return (l != 0) ? l : exp_lo(d); endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(int code, int div, int lead, int trail);
    cfg_we_i = 1'b1; cfg_len_i = 4'(code); cfg_div_i = 8'(div);
    cfg_lead_i = 8'(lead); cfg_trail_i = 8'(trail);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 20000 && !done_o; k++) @(negedge clk);
    repeat (260) @(negedge clk);
  endtask

  task automatic do_xfer(int code, int div, int lead, int trail,
                         logic [15:0] tx, logic [15:0] sw, bit mid_start);
    int n, c, rises, first_rise, last_rise, last_fall, done_c;
    int bad_per, bad_hi, bad_mosi;
    logic [15:0] mask, mosi_word, rx;
    logic prev, rise_mosi, cs_done;
    n = 8 + code;
    mask = 16'((32'd1 << n) - 1);
    cfg_write(code, div, lead, trail);
    cur_n = n; cur_sw = sw; bi = 0;
    tx_data_i = tx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(cs_no == 1'b0, "R4", "cs low after start", int'(cs_no), 0);
    c = 0; rises = 0; first_rise = -1; last_rise = 0; last_fall = -1; done_c = -2;
    bad_per = 0; bad_hi = 0; bad_mosi = 0; mosi_word = '0; rx = '0;
    prev = 1'b0; rise_mosi = 1'b0; cs_done = 1'b0;
    while (c < 20000) begin
      if (sck_o && !prev) begin
        if (first_rise < 0) first_rise = c;
        else if (c - last_rise != exp_hi(div) + exp_lo(div)) bad_per++;
        last_rise = c; rises++;
        mosi_word = {mosi_word[14:0], mosi_o};
        rise_mosi = mosi_o;
      end
      if (sck_o && mosi_o != rise_mosi) bad_mosi++;
      if (!sck_o && prev) begin
        if (c - last_rise != exp_hi(div)) bad_hi++;
        last_fall = c; bi++;
      end
      if (done_o) begin
        done_c = c; rx = rx_data_o; cs_done = cs_no;
        break;
      end
      prev = sck_o;
      if (mid_start && c == 2) begin start_i = 1'b1; tx_data_i = ~tx; end
      else start_i = 1'b0;
      @(negedge clk);
      c++;
    end
    start_i = 1'b0;
    chk(first_rise == exp_lead(lead, div), "R4", "lead cycles", first_rise, exp_lead(lead, div));
    chk(bad_per == 0, "R2", "period mismatches", bad_per, 0);
    chk(bad_hi == 0, "R2", "high phase mismatches", bad_hi, 0);
    chk(rises == n, "R1", "sck pulses", rises, n);
    chk(mosi_word == (tx & mask), "R1", "mosi word (R9 when mid start)", int'(mosi_word), int'(tx & mask));
    chk(bad_mosi == 0, "R3", "mosi moved while sck high", bad_mosi, 0);
    chk(rx == (sw & mask), "R1", "rx word", int'(rx), int'(sw & mask));
    chk(done_c == last_fall, "R6", "done on last fall", done_c, last_fall);
    chk(cs_done == 1'b1, "R5", "cs high at last fall", int'(cs_done), 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R6", "done one cycle", int'(done_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(cs_no == 1'b1, "R8", "cs after reset", int'(cs_no), 1);
    chk(sck_o == 1'b0, "R8", "sck after reset", int'(sck_o), 0);
    chk(done_o == 1'b0, "R8", "done after reset", int'(done_o), 0);
    chk(rx_data_o == '0, "R8", "rx after reset", int'(rx_data_o), 0);
    chk(cfg_err_o == 1'b0, "R8", "err after reset", int'(cfg_err_o), 0);
    // R8/R7 start with divider still 0
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk(cfg_err_o == 1'b1, "R7", "err on zero divider", int'(cfg_err_o), 1);
    chk(cs_no == 1'b1, "R8", "start ignored after reset", int'(cs_no), 1);
    // R10 write and start in the same cycle
    cfg_we_i = 1'b1; cfg_len_i = 4'd0; cfg_div_i = 8'd2; cfg_lead_i = 8'd1; cfg_trail_i = 8'd0;
    start_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0; start_i = 1'b0;
    chk(cs_no == 1'b1, "R10", "start used old settings", int'(cs_no), 1);
    chk(cfg_err_o == 1'b0, "R10", "clear wins over set", int'(cfg_err_o), 0);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk(cs_no == 1'b0, "R10", "new settings used next cycle", int'(cs_no), 0);
    wait_done();
    // R7 reserved length code
    cfg_write(9, 4, 0, 0);
    chk(cfg_err_o == 1'b0, "R7", "invalid write no set", int'(cfg_err_o), 0);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk(cfg_err_o == 1'b1, "R7", "err on reserved code", int'(cfg_err_o), 1);
    chk(cs_no == 1'b1, "R7", "reserved code start ignored", int'(cs_no), 1);
    cfg_write(2, 0, 0, 0);
    chk(cfg_err_o == 1'b1, "R7", "invalid write keeps err", int'(cfg_err_o), 1);
    cfg_write(8, 3, 0, 0);
    chk(cfg_err_o == 1'b0, "R7", "valid write clears err", int'(cfg_err_o), 0);
    // directed corners
    do_xfer(8, 255, 0, 0, 16'hA5C3, 16'h3C5A, 1'b0);
    do_xfer(0, 1, 0, 0, 16'hFF96, 16'h0069, 1'b0);
    do_xfer(0, 3, 255, 2, 16'h0081, 16'h00FF, 1'b1);
    do_xfer(4, 2, 1, 0, 16'hFFFF, 16'hFFFF, 1'b0);
    // R5 hold-off: start one cycle early, held into the first free cycle
    do_xfer(1, 4, 2, 6, 16'h0155, 16'h00AA, 1'b0);
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk(cs_no == 1'b1, "R5", "start held off in trail", int'(cs_no), 1);
    @(negedge clk);
    start_i = 1'b0;
    chk(cs_no == 1'b0, "R5", "start accepted after trail", int'(cs_no), 0);
    wait_done();
    // constrained random
    for (int i = 0; i < 16; i++) begin
      do_xfer(int'($urandom_range(0, 8)), int'($urandom_range(1, 12)),
              int'($urandom_range(0, 9)), int'($urandom_range(0, 5)),
              16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)));
      repeat (6) @(negedge clk);
    end
    summary();
    $finish;
  end
endmodule